// File: doc/BRIEF.md
# Trap and Return Exception Controller

This block holds the processor status word and the registers that save state around exceptions. It carries out four commands: a software trap, a return from exception, interrupt disable and interrupt enable. A trap saves the return address and the current status, writes a cause code, raises the exception-active and interrupt-disable flags, and sends the fetch unit to one of two fixed entry addresses. A return restores the status and sends fetch back, using either the non-maskable save pair or the ordinary exception save pair.

The pipeline presents at most one command per cycle, with the current PC and a 5-bit trap vector. A redirect request appears on the cycle after a trap or a return. A separate write port loads any of the six registers directly. Test setups use it to seed the save registers. Interrupt sources and non-maskable event generation are outside this block.

Top module: `trap_return_ctrl`

## Requirements
- R1: After reset, the status register reads 0x20 (only the interrupt-disable bit 5 set). Every save register and the cause register read 0, and redirect_valid is low.
- R2: A trap command (cmd_op = 2'b00) loads the exception save PC with cur_pc + 4. It loads the exception save status with the status value held before the trap.
- R3: On a trap, cause bits [15:0] become 0x40 + trap_vec and cause bits [31:16] keep their value.
- R4: On a trap, status bits 6 (exception active) and 5 (interrupt disable) are set. All other status bits keep their value.
- R5: After a trap, redirect_pc is 0x40 when trap_vec is below 16, and 0x50 when trap_vec is 16 to 31.
- R6: A return command (cmd_op = 2'b01) picks the non-maskable pair when status bit 7 is set and bit 6 is clear. In that case redirect_pc takes the non-maskable save PC and status takes the non-maskable save status. In every other case, the exception save PC and exception save status are used.
- R7: Disable (cmd_op = 2'b10) sets status bit 5, and enable (cmd_op = 2'b11) clears it. Neither command changes any other status bit or any save or cause register, and neither causes a redirect.
- R8: redirect_valid is high for exactly the one cycle after an accepted trap or return, and low in every other cycle.
- R9: When wr_en is high and cmd_valid is low, wr_data is loaded into the register chosen by wr_sel: 0 status (low 8 bits), 1 exception save PC, 2 exception save status, 3 non-maskable save PC, 4 non-maskable save status, 5 cause. Codes 6 and 7 change nothing. A write that arrives together with cmd_valid is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation: 00 trap, 01 return, 10 disable, 11 enable |
| cur_pc | input | 32 | PC of the commanding instruction |
| trap_vec | input | 5 | Trap vector number |
| wr_en | input | 1 | Direct register write strobe |
| wr_sel | input | 3 | Direct write target select |
| wr_data | input | 32 | Direct write data |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_pc | output | 32 | Fetch redirect address |
| status_o | output | 8 | Status register |
| exc_pc_o | output | 32 | Exception save PC |
| exc_stat_o | output | 8 | Exception save status |
| nmi_pc_o | output | 32 | Non-maskable save PC |
| nmi_stat_o | output | 8 | Non-maskable save status |
| cause_o | output | 32 | Cause register |

## Verification
The assertions check on every cycle the things a trap must do: the flags it raises, the saved return address, the preserved upper half of the cause register, and the two possible entry addresses. They also check that an enable always clears the disable flag and that a redirect only follows an accepted trap or return. Only the bench scenarios can show the choice between the two return save pairs. The bench scenarios also cover the vector boundary between 15 and 16, writes that a simultaneous command overrides, and the reset values. A reference model in the bench predicts each cycle's register contents for these checks.

// File: rtl/trc_pkg.sv
package trc_pkg;

   typedef enum logic [1:0] {
      OP_TRAP    = 2'b00,
      OP_RETURN  = 2'b01,
      OP_IRQ_OFF = 2'b10,
      OP_IRQ_ON  = 2'b11
   } trc_op_e;

   typedef enum logic [2:0] {
      SEL_STATUS   = 3'd0,
      SEL_EXC_PC   = 3'd1,
      SEL_EXC_STAT = 3'd2,
      SEL_NMI_PC   = 3'd3,
      SEL_NMI_STAT = 3'd4,
      SEL_CAUSE    = 3'd5
   } trc_sel_e;

   // status bit positions
   localparam int unsigned ST_ZERO  = 0;
   localparam int unsigned ST_SIGN  = 1;
   localparam int unsigned ST_OVF   = 2;
   localparam int unsigned ST_CARRY = 3;
   localparam int unsigned ST_SATUR = 4;
   localparam int unsigned ST_IDIS  = 5;
   localparam int unsigned ST_EXACT = 6;
   localparam int unsigned ST_NMACT = 7;

   typedef struct packed {
      logic trap;
      logic ret;
      logic irq_off;
      logic irq_on;
   } trc_fire_t;

endpackage

// File: rtl/trc_decode.sv
module trc_decode
   import trc_pkg::*;
(
   input  logic       cmd_valid,
   input  logic [1:0] cmd_op,
   input  logic       wr_en,
   output trc_fire_t  fire,
   output logic       wr_ok
);
   trc_op_e op;

   always_comb begin
      op           = trc_op_e'(cmd_op);
      fire         = '0;
      fire.trap    = cmd_valid && (op == OP_TRAP);
      fire.ret     = cmd_valid && (op == OP_RETURN);
      fire.irq_off = cmd_valid && (op == OP_IRQ_OFF);
      fire.irq_on  = cmd_valid && (op == OP_IRQ_ON);
      wr_ok        = wr_en && !cmd_valid;
   end

   always_comb begin
      assert ($onehot0(fire));
   end
endmodule

// File: rtl/trc_status_file.sv
module trc_status_file
   import trc_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned STAT_W     = 8,
   parameter int unsigned VEC_W      = 5,
   parameter int unsigned CAUSE_LO_W = 16,
   parameter int unsigned CAUSE_BASE = 'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  trc_fire_t         fire,
   input  logic [XLEN-1:0]   cur_pc,
   input  logic [VEC_W-1:0]  trap_vec,
   input  logic              wr_ok,
   input  logic [2:0]        wr_sel,
   input  logic [XLEN-1:0]   wr_data,
   output logic [STAT_W-1:0] stat_q,
   output logic [XLEN-1:0]   exc_pc_q,
   output logic [STAT_W-1:0] exc_stat_q,
   output logic [XLEN-1:0]   nmi_pc_q,
   output logic [STAT_W-1:0] nmi_stat_q,
   output logic [XLEN-1:0]   cause_q,
   output logic [XLEN-1:0]   ret_pc
);
   localparam logic [STAT_W-1:0] STAT_RST  = STAT_W'(1) << ST_IDIS;
   localparam logic [STAT_W-1:0] TRAP_SET  = (STAT_W'(1) << ST_IDIS) | (STAT_W'(1) << ST_EXACT);
   localparam logic [XLEN-1:0]   PC_STEP   = XLEN'(4);

   logic                  use_nmi;
   logic [STAT_W-1:0]     ret_stat;
   logic [CAUSE_LO_W-1:0] cause_lo_next;
   trc_sel_e              sel;

   assign sel           = trc_sel_e'(wr_sel);
   assign use_nmi       = stat_q[ST_NMACT] && !stat_q[ST_EXACT];
   assign ret_pc        = use_nmi ? nmi_pc_q   : exc_pc_q;
   assign ret_stat      = use_nmi ? nmi_stat_q : exc_stat_q;
   assign cause_lo_next = CAUSE_LO_W'(CAUSE_BASE) + CAUSE_LO_W'(trap_vec);

   // status register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= STAT_RST;
      end else if (fire.trap) begin
         stat_q <= stat_q | TRAP_SET;
      end else if (fire.ret) begin
         stat_q <= ret_stat;
      end else if (fire.irq_off) begin
         stat_q[ST_IDIS] <= 1'b1;
      end else if (fire.irq_on) begin
         stat_q[ST_IDIS] <= 1'b0;
      end else if (wr_ok && sel == SEL_STATUS) begin
         stat_q <= wr_data[STAT_W-1:0];
      end
   end

   // exception save pair
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exc_pc_q   <= '0;
         exc_stat_q <= '0;
      end else if (fire.trap) begin
         exc_pc_q   <= cur_pc + PC_STEP;
         exc_stat_q <= stat_q;
      end else if (wr_ok) begin
         if (sel == SEL_EXC_PC)   exc_pc_q   <= wr_data;
         if (sel == SEL_EXC_STAT) exc_stat_q <= wr_data[STAT_W-1:0];
      end
   end

   // non-maskable save pair: only the write port changes it
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nmi_pc_q   <= '0;
         nmi_stat_q <= '0;
      end else if (wr_ok) begin
         if (sel == SEL_NMI_PC)   nmi_pc_q   <= wr_data;
         if (sel == SEL_NMI_STAT) nmi_stat_q <= wr_data[STAT_W-1:0];
      end
   end

   // cause register: a variant keeps an upper field when the code is narrower
   if (CAUSE_LO_W < XLEN) begin : g_cause_split
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cause_q <= '0;
         end else if (fire.trap) begin
            cause_q <= {cause_q[XLEN-1:CAUSE_LO_W], cause_lo_next};
         end else if (wr_ok && sel == SEL_CAUSE) begin
            cause_q <= wr_data;
         end
      end

      p_cause_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
         fire.trap |=> cause_q[XLEN-1:CAUSE_LO_W] == $past(cause_q[XLEN-1:CAUSE_LO_W]));
   end else begin : g_cause_full
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cause_q <= '0;
         end else if (fire.trap) begin
            cause_q <= XLEN'(cause_lo_next);
         end else if (wr_ok && sel == SEL_CAUSE) begin
            cause_q <= wr_data;
         end
      end
   end

   p_trap_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fire.trap |=> stat_q[ST_IDIS] && stat_q[ST_EXACT]);

   p_trap_save_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fire.trap |=> exc_pc_q == $past(cur_pc) + PC_STEP && exc_stat_q == $past(stat_q));

   p_enable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fire.irq_on |=> !stat_q[ST_IDIS]);

   p_disable_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fire.irq_off |=> stat_q[ST_IDIS] && $stable(exc_pc_q));
endmodule

// File: rtl/trc_redirect.sv
module trc_redirect #(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned VEC_W     = 5,
   parameter int unsigned VEC_SPLIT = 16,
   parameter int unsigned TGT_LO    = 'h40,
   parameter int unsigned TGT_HI    = 'h50
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trap_fire,
   input  logic             ret_fire,
   input  logic [VEC_W-1:0] trap_vec,
   input  logic [XLEN-1:0]  ret_pc,
   output logic             redirect_valid,
   output logic [XLEN-1:0]  redirect_pc
);
   localparam logic [VEC_W-1:0] SPLIT_V = VEC_W'(VEC_SPLIT);

   logic [XLEN-1:0] trap_tgt;

   assign trap_tgt = (trap_vec < SPLIT_V) ? XLEN'(TGT_LO) : XLEN'(TGT_HI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redirect_valid <= 1'b0;
         redirect_pc    <= '0;
      end else begin
         redirect_valid <= trap_fire || ret_fire;
         if (trap_fire)     redirect_pc <= trap_tgt;
         else if (ret_fire) redirect_pc <= ret_pc;
      end
   end

   p_redirect_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> $past(trap_fire || ret_fire));

   p_trap_target_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_fire && trap_vec < SPLIT_V) |=> redirect_valid && redirect_pc == XLEN'(TGT_LO));

   p_trap_target_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_fire && trap_vec >= SPLIT_V) |=> redirect_valid && redirect_pc == XLEN'(TGT_HI));
endmodule

// File: rtl/trap_return_ctrl.sv
module trap_return_ctrl
   import trc_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned STAT_W     = 8,
   parameter int unsigned VEC_W      = 5,
   parameter int unsigned VEC_SPLIT  = 16,
   parameter int unsigned CAUSE_LO_W = 16,
   parameter int unsigned CAUSE_BASE = 'h40,
   parameter int unsigned TGT_LO     = 'h40,
   parameter int unsigned TGT_HI     = 'h50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [XLEN-1:0]   cur_pc,
   input  logic [VEC_W-1:0]  trap_vec,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [XLEN-1:0]   wr_data,
   output logic              redirect_valid,
   output logic [XLEN-1:0]   redirect_pc,
   output logic [STAT_W-1:0] status_o,
   output logic [XLEN-1:0]   exc_pc_o,
   output logic [STAT_W-1:0] exc_stat_o,
   output logic [XLEN-1:0]   nmi_pc_o,
   output logic [STAT_W-1:0] nmi_stat_o,
   output logic [XLEN-1:0]   cause_o
);
   // elaboration-time parameter checks
   if (STAT_W <= ST_NMACT) begin : g_bad_stat
      $error("STAT_W must hold every status flag");
   end
   if (CAUSE_LO_W <= VEC_W || CAUSE_LO_W > XLEN) begin : g_bad_cause
      $error("CAUSE_LO_W must exceed VEC_W and fit in XLEN");
   end
   if (VEC_SPLIT >= (1 << VEC_W)) begin : g_bad_split
      $error("VEC_SPLIT must be a reachable vector");
   end
   if (XLEN < STAT_W) begin : g_bad_xlen
      $error("XLEN must be at least STAT_W");
   end

   trc_fire_t       fire;
   logic            wr_ok;
   logic [XLEN-1:0] ret_pc;

   trc_decode u_decode (
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .wr_en     (wr_en),
      .fire      (fire),
      .wr_ok     (wr_ok)
   );

   trc_status_file #(
      .XLEN       (XLEN),
      .STAT_W     (STAT_W),
      .VEC_W      (VEC_W),
      .CAUSE_LO_W (CAUSE_LO_W),
      .CAUSE_BASE (CAUSE_BASE)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (fire),
      .cur_pc     (cur_pc),
      .trap_vec   (trap_vec),
      .wr_ok      (wr_ok),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .stat_q     (status_o),
      .exc_pc_q   (exc_pc_o),
      .exc_stat_q (exc_stat_o),
      .nmi_pc_q   (nmi_pc_o),
      .nmi_stat_q (nmi_stat_o),
      .cause_q    (cause_o),
      .ret_pc     (ret_pc)
   );

   trc_redirect #(
      .XLEN      (XLEN),
      .VEC_W     (VEC_W),
      .VEC_SPLIT (VEC_SPLIT),
      .TGT_LO    (TGT_LO),
      .TGT_HI    (TGT_HI)
   ) u_redirect (
      .clk            (clk),
      .rst_n          (rst_n),
      .trap_fire      (fire.trap),
      .ret_fire       (fire.ret),
      .trap_vec       (trap_vec),
      .ret_pc         (ret_pc),
      .redirect_valid (redirect_valid),
      .redirect_pc    (redirect_pc)
   );
endmodule

// File: tb/trap_return_ctrl_tb.sv
`timescale 1ns/1ps
module trap_return_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = 2'b00;
   logic [31:0] cur_pc = '0;
   logic [4:0]  trap_vec = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic        redirect_valid;
   logic [31:0] redirect_pc;
   logic [7:0]  status_o, exc_stat_o, nmi_stat_o;
   logic [31:0] exc_pc_o, nmi_pc_o, cause_o;

   always #4 clk = ~clk;

   trap_return_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cur_pc(cur_pc), .trap_vec(trap_vec), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .status_o(status_o), .exc_pc_o(exc_pc_o), .exc_stat_o(exc_stat_o),
      .nmi_pc_o(nmi_pc_o), .nmi_stat_o(nmi_stat_o), .cause_o(cause_o)
   );

   typedef struct {
      string       tag;
      logic        rv;
      logic [31:0] rpc;
      logic [7:0]  st, es, ns;
      logic [31:0] epc, npc, cs;
   } exp_t;

   exp_t q[$];
   int   n_tests = 0;
   int   n_fail  = 0;

   // reference model state
   logic [7:0]  m_st = 8'h20, m_es = '0, m_ns = '0;
   logic [31:0] m_epc = '0, m_npc = '0, m_cs = '0;

   task automatic step(input logic v, input logic [1:0] op, input logic [31:0] pc,
                       input logic [4:0] vec, input logic we, input logic [2:0] sel,
                       input logic [31:0] wd, input string tag);
      exp_t e;
      @(negedge clk);
      cmd_valid = v; cmd_op = op; cur_pc = pc; trap_vec = vec;
      wr_en = we; wr_sel = sel; wr_data = wd;
      e.tag = tag; e.rv = 1'b0; e.rpc = '0;
      if (v && op == 2'b00) begin
         e.rv = 1'b1; e.rpc = (vec < 5'd16) ? 32'h40 : 32'h50;
         m_epc = pc + 32'd4; m_es = m_st;
         m_cs = (m_cs & 32'hFFFF_0000) | (32'h40 + {27'd0, vec});
         m_st = m_st | 8'h60;
      end else if (v && op == 2'b01) begin
         e.rv = 1'b1;
         if (m_st[7] && !m_st[6]) begin e.rpc = m_npc; m_st = m_ns; end
         else                     begin e.rpc = m_epc; m_st = m_es; end
      end else if (v && op == 2'b10) begin
         m_st[5] = 1'b1;
      end else if (v && op == 2'b11) begin
         m_st[5] = 1'b0;
      end else if (!v && we) begin
         case (sel)
            3'd0: m_st  = wd[7:0];
            3'd1: m_epc = wd;
            3'd2: m_es  = wd[7:0];
            3'd3: m_npc = wd;
            3'd4: m_ns  = wd[7:0];
            3'd5: m_cs  = wd;
            default: ;
         endcase
      end
      e.st = m_st; e.es = m_es; e.ns = m_ns; e.epc = m_epc; e.npc = m_npc; e.cs = m_cs;
      q.push_back(e);
   endtask

   task automatic idle(input string tag);
      step(1'b0, 2'b00, '0, '0, 1'b0, '0, '0, tag);
   endtask

   function automatic void cmp(input string tag, input string f,
                               input logic [31:0] act, input logic [31:0] exp);
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, f, act, exp);
      end
   endfunction

   // monitor: compares after the edge that follows each driven cycle
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_tests++;
            cmp(e.tag, "redirect_valid", {31'd0, redirect_valid}, {31'd0, e.rv});
            if (e.rv) cmp(e.tag, "redirect_pc", redirect_pc, e.rpc);
            cmp(e.tag, "status", {24'd0, status_o}, {24'd0, e.st});
            cmp(e.tag, "exc_pc", exc_pc_o, e.epc);
            cmp(e.tag, "exc_stat", {24'd0, exc_stat_o}, {24'd0, e.es});
            cmp(e.tag, "nmi_pc", nmi_pc_o, e.npc);
            cmp(e.tag, "nmi_stat", {24'd0, nmi_stat_o}, {24'd0, e.ns});
            cmp(e.tag, "cause", cause_o, e.cs);
         end
      end
   end

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      idle("R1 reset values");
      idle("R8 no redirect when idle");
      // R9 preload through write port
      step(1'b0, 2'b00, '0, '0, 1'b1, 3'd3, 32'h0000_1000, "R9 write nmi pc");
      step(1'b0, 2'b00, '0, '0, 1'b1, 3'd4, 32'h0000_0081, "R9 write nmi status");
      step(1'b0, 2'b00, '0, '0, 1'b1, 3'd5, 32'hABCD_0000, "R9 write cause");
      step(1'b0, 2'b00, '0, '0, 1'b1, 3'd7, 32'hFFFF_FFFF, "R9 unused select");
      // R9 write ignored with a command; R7 enable
      step(1'b1, 2'b11, '0, '0, 1'b1, 3'd3, 32'h0000_DEAD, "R9 R7 write blocked by enable");
      step(1'b1, 2'b10, '0, '0, 1'b0, '0, '0, "R7 disable");
      step(1'b1, 2'b11, '0, '0, 1'b0, '0, '0, "R7 enable");
      step(1'b0, 2'b00, '0, '0, 1'b1, 3'd0, 32'h0000_0009, "R9 write status");
      // trap vec 3
      step(1'b1, 2'b00, 32'h0000_0200, 5'd3, 1'b0, '0, '0, "R2 R3 R4 R5 trap vec 3");
      idle("R8 redirect drops");
      step(1'b1, 2'b01, '0, '0, 1'b0, '0, '0, "R6 return via exception pair");
      // trap vector boundary
      step(1'b1, 2'b00, 32'h0000_0300, 5'd15, 1'b0, '0, '0, "R5 trap vec 15");
      step(1'b1, 2'b00, 32'h0000_0400, 5'd16, 1'b0, '0, '0, "R5 R3 trap vec 16");
      step(1'b1, 2'b00, 32'h0000_0500, 5'd31, 1'b0, '0, '0, "R5 R3 trap vec 31");
      // R6 non-maskable pair
      step(1'b0, 2'b00, '0, '0, 1'b1, 3'd0, 32'h0000_0080, "R9 status NP only");
      step(1'b1, 2'b01, '0, '0, 1'b0, '0, '0, "R6 return via nmi pair");
      step(1'b0, 2'b00, '0, '0, 1'b1, 3'd0, 32'h0000_00C0, "R9 status NP and EP");
      step(1'b1, 2'b01, '0, '0, 1'b0, '0, '0, "R6 return with both flags");
      step(1'b1, 2'b10, '0, '0, 1'b0, '0, '0, "R7 R8 disable no redirect");
      idle("R8 final idle");
      idle("final");
      repeat (3) @(posedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule